// File: doc/BRIEF.md
# Serial Codec Command and Status Link

This block is the controller end of a serial link to one or two audio codecs. The codec supplies the bit clock. All serial logic runs on that clock. The controller counts 256-bit frames and drives a frame marker. When the host has written a command word, the controller sends it in the command slots of exactly one frame. It samples both serial inputs and keeps the most recent status word that a codec marked valid.

The host side is a small word-addressed register port on the system clock. The host writes the command word and reads back the status word. A second serial input, used by an optional second codec, can also return status. The same input can raise a wake request while the bit clock is stopped. That request can be routed to an interrupt output. The two clock domains exchange data only through toggle handshakes and stable-data captures, so a command word never leaves the controller half-updated.

Top module: `ac_link_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low. The registers are: word 0 wake status, word 1 interrupt enable, word 2 codec status, word 3 command. Read data appears on `reg_rdata` one system clock after the `reg_rd` strobe.
- R2: A frame is 256 bit clocks long. `ac_sync` is high for the first 16 bit clocks of every frame and low for the other 240.
- R3: Each accepted write to word 3 is sent in exactly one frame. In that frame, frame positions 0, 1 and 2 (tag bits 15, 14, 13) are 1. Positions 16 to 35 carry command bits 31:16 MSB first, then four zeros. Positions 36 to 55 carry command bits 15:0 MSB first, then four zeros. All other positions are 0.
- R4: A frame sent while no command is pending carries zeros in every position.
- R5: A write to word 3 is dropped if the previous command has not yet begun transmission. Reading word 3 returns the last accepted command word.
- R6: Serial inputs are sampled on the falling bit clock edge. If input positions 1 and 2 are both 1, the status register becomes the concatenation of two values: bits 19:4 of slot 1 (positions 16 to 35) in the upper half, and bits 19:4 of slot 2 (positions 36 to 55) in the lower half.
- R7: If either input position 1 or input position 2 is 0, that frame leaves the status register unchanged. An input tied low therefore never changes it.
- R8: Status can come from either serial input. When both inputs mark a frame valid, input 0 wins.
- R9: Bit 0 of word 0 becomes 1 when `ac_sdin1` is high and the bit clock has shown no edge for `IDLE_CYC` system clocks. Activity on `ac_sdin1` while frames are running does not set it.
- R10: Writing 1 to bit 0 of word 0 clears the wake flag.
- R11: `irq` is high exactly when bit 0 of word 1 (read back at that bit) and the wake flag are both 1, delayed by one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the register port |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Wake interrupt |
| bit_clk | input | 1 | Serial bit clock from the codec |
| ac_sync | output | 1 | Frame marker |
| ac_sdout | output | 1 | Serial data to the codecs |
| ac_sdin0 | input | 1 | Serial data from the primary codec |
| ac_sdin1 | input | 1 | Serial data from the optional codec, also the wake line |

## Verification
Command words are sent with contrasting bit patterns: a mixed word, an all-ones upper half over a zero lower half, and single bits at the slot edges. A wrong bit order or a wrong slot offset therefore shows up as a mismatch. A back-to-back second write shows whether the block drops it or sends it. The status path gets frames that are fully valid, frames with only one of the two tag bits set, frames on the second input alone and frames on both inputs. These tell apart the tag test, the capture edge and the input priority. The wake path is tried with the bit clock stopped, with the line both low and high. The same line also toggles freely during running frames.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;
  localparam int FRAME_BITS_D = 256;
  localparam int TAG_BITS_D   = 16;
  localparam int SLOT_BITS_D  = 20;
  localparam int WORD_W_D     = 32;

  typedef enum logic [1:0] {
    REG_WAKE = 2'd0,
    REG_IEN  = 2'd1,
    REG_STAT = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ac_frame_gen.sv
module ac_frame_gen
  import ac_link_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int TAG_BITS   = TAG_BITS_D,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             bclk,
  input  logic             brst,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] pos_n,
  output logic             sync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  always_comb pos_n = (pos == LAST) ? '0 : pos + 1'b1;

  always_ff @(posedge bclk) begin
    if (brst) begin
      pos  <= LAST;
      sync <= 1'b0;
    end else begin
      pos  <= pos_n;
      sync <= (pos_n < CNT_W'(TAG_BITS));
    end
  end

  assert_sync_start_R2: assert property (@(posedge bclk) disable iff (brst)
    $rose(sync) |-> (pos == '0));
  assert_sync_end_R2: assert property (@(posedge bclk) disable iff (brst)
    (sync && pos == CNT_W'(TAG_BITS - 1)) |=> !sync);
endmodule

// File: rtl/ac_cmd_tx.sv
module ac_cmd_tx
  import ac_link_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int TAG_BITS   = TAG_BITS_D,
  parameter int SLOT_BITS  = SLOT_BITS_D,
  parameter int WORD_W     = WORD_W_D,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic [CNT_W-1:0]  pos_n,
  input  logic              req_t,
  input  logic [WORD_W-1:0] cmd_src,
  output logic              ack_t,
  output logic              sdo
);
  localparam int HALF = WORD_W / 2;
  localparam int PAD  = FRAME_BITS - TAG_BITS - 2 * SLOT_BITS;
  localparam int FILL = SLOT_BITS - HALF;

  logic [2:0]          req_s;
  logic                cap, fstart, pending, send_q, send_n;
  logic [WORD_W-1:0]   cmd_b, cmd_q, cmd_n;
  logic [FRAME_BITS-1:0] fvec;

  assign cap    = req_s[2] ^ req_s[1];
  assign fstart = (pos_n == '0);
  assign send_n = fstart ? pending : send_q;
  assign cmd_n  = fstart ? cmd_b : cmd_q;

  always_comb begin
    fvec = {send_n, send_n, send_n, {(TAG_BITS-3){1'b0}},
            cmd_n[WORD_W-1:HALF], {FILL{1'b0}},
            cmd_n[HALF-1:0], {FILL{1'b0}}, {PAD{1'b0}}};
    if (!send_n) fvec = '0;
  end

  always_ff @(posedge bclk) begin
    if (brst) begin
      req_s   <= '0;
      pending <= 1'b0;
      cmd_b   <= '0;
      cmd_q   <= '0;
      send_q  <= 1'b0;
      ack_t   <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_t};
      if (cap) begin
        cmd_b   <= cmd_src;
        pending <= 1'b1;
      end else if (fstart && pending) begin
        pending <= 1'b0;
        ack_t   <= ~ack_t;
      end
      if (fstart) begin
        send_q <= pending;
        cmd_q  <= cmd_b;
      end
      sdo <= fvec[CNT_W'(FRAME_BITS - 1) - pos_n];
    end
  end

  assert_send_once_R3: assert property (@(posedge bclk) disable iff (brst)
    (fstart && pending && !cap) |=> (!pending && send_q));
  assert_no_overwrite_R5: assert property (@(posedge bclk) disable iff (brst)
    pending |-> !cap);
endmodule

// File: rtl/ac_stat_rx_lane.sv
module ac_stat_rx_lane
  import ac_link_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int TAG_BITS   = TAG_BITS_D,
  parameter int SLOT_BITS  = SLOT_BITS_D,
  parameter int WORD_W     = WORD_W_D,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic              bclk,
  input  logic              brst,
  input  logic [CNT_W-1:0]  pos,
  input  logic              sdin,
  output logic              hit,
  output logic [WORD_W-1:0] word
);
  localparam int HALF = WORD_W / 2;
  localparam logic [CNT_W-1:0] END1 = CNT_W'(TAG_BITS + SLOT_BITS - 1);
  localparam logic [CNT_W-1:0] END2 = CNT_W'(TAG_BITS + 2 * SLOT_BITS - 1);

  logic [SLOT_BITS-1:0] sh, full;
  logic [HALF-1:0]      addr_q;
  logic                 v1, v2;

  assign full = {sh[SLOT_BITS-2:0], sdin};

  always_ff @(negedge bclk) begin
    if (brst) begin
      sh     <= '0;
      addr_q <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      hit    <= 1'b0;
      word   <= '0;
    end else begin
      sh  <= full;
      hit <= 1'b0;
      if (pos == CNT_W'(1)) v1 <= sdin;
      if (pos == CNT_W'(2)) v2 <= sdin;
      if (pos == END1) addr_q <= full[SLOT_BITS-1 -: HALF];
      if (pos == END2) begin
        word <= {addr_q, full[SLOT_BITS-1 -: HALF]};
        hit  <= v1 & v2;
      end
    end
  end

  assert_hit_after_slot2_R6: assert property (@(negedge bclk) disable iff (brst)
    hit |-> (pos == END2 + 1'b1));
endmodule

// File: rtl/ac_link_ctrl.sv
module ac_link_ctrl
  import ac_link_pkg::*;
#(
  parameter int FRAME_BITS = FRAME_BITS_D,
  parameter int TAG_BITS   = TAG_BITS_D,
  parameter int SLOT_BITS  = SLOT_BITS_D,
  parameter int WORD_W     = WORD_W_D,
  parameter int LANES      = 2,
  parameter int IDLE_CYC   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_word,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              bit_clk,
  output logic              ac_sync,
  output logic              ac_sdout,
  input  logic              ac_sdin0,
  input  logic              ac_sdin1
);
  localparam int CNT_W  = $clog2(FRAME_BITS);
  localparam int IDLE_W = $clog2(IDLE_CYC + 1);

  // ---------------- bit clock domain ----------------
  logic [1:0]        brst_s = 2'b11;
  logic              brst;
  logic [CNT_W-1:0]  pos, pos_n;
  logic              ack_t, act_t, stat_t;
  logic [LANES-1:0]  sdin, hit;
  logic [WORD_W-1:0] word [LANES];
  logic [WORD_W-1:0] stat_b, sel_word;

  // host side signals that the bit clock side reads
  logic              req_t;
  logic [WORD_W-1:0] cmd_hold;

  assign brst = brst_s[1];
  assign sdin = {ac_sdin1, ac_sdin0};

  always_ff @(posedge bit_clk) begin
    brst_s <= {brst_s[0], rst};
    act_t  <= brst ? 1'b0 : ~act_t;
  end

  ac_frame_gen #(.FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS)) u_fgen (
    .bclk(bit_clk), .brst(brst), .pos(pos), .pos_n(pos_n), .sync(ac_sync));

  ac_cmd_tx #(.FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS),
              .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W)) u_tx (
    .bclk(bit_clk), .brst(brst), .pos_n(pos_n), .req_t(req_t),
    .cmd_src(cmd_hold), .ack_t(ack_t), .sdo(ac_sdout));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ac_stat_rx_lane #(.FRAME_BITS(FRAME_BITS), .TAG_BITS(TAG_BITS),
                      .SLOT_BITS(SLOT_BITS), .WORD_W(WORD_W)) u_rx (
      .bclk(bit_clk), .brst(brst), .pos(pos), .sdin(sdin[g]),
      .hit(hit[g]), .word(word[g]));
  end

  // lowest-numbered lane wins
  always_comb begin
    sel_word = word[0];
    for (int i = LANES - 1; i >= 0; i--)
      if (hit[i]) sel_word = word[i];
  end

  always_ff @(negedge bit_clk) begin
    if (brst) begin
      stat_b <= '0;
      stat_t <= 1'b0;
    end else if (|hit) begin
      stat_b <= sel_word;
      stat_t <= ~stat_t;
    end
  end

  assert_status_only_on_hit_R7: assert property (@(negedge bit_clk) disable iff (brst)
    !(|hit) |=> $stable(stat_b));

  // ---------------- system clock domain ----------------
  reg_sel_e          sel;
  logic [1:0]        ack_s, wk_s;
  logic [2:0]        stat_s, act_s;
  logic [WORD_W-1:0] stat_h;
  logic [IDLE_W-1:0] idle_cnt;
  logic              busy, idle, wake, ien, wake_clr;

  assign sel      = reg_sel_e'(reg_word);
  assign busy     = req_t != ack_s[1];
  assign idle     = (idle_cnt == IDLE_W'(IDLE_CYC));
  assign wake_clr = reg_wr && sel == REG_WAKE && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      req_t     <= 1'b0;
      cmd_hold  <= '0;
      ack_s     <= '0;
      stat_s    <= '0;
      act_s     <= '0;
      wk_s      <= '0;
      stat_h    <= '0;
      idle_cnt  <= '0;
      wake      <= 1'b0;
      ien       <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ack_s  <= {ack_s[0], ack_t};
      stat_s <= {stat_s[1:0], stat_t};
      act_s  <= {act_s[1:0], act_t};
      wk_s   <= {wk_s[0], ac_sdin1};
      if (stat_s[2] ^ stat_s[1]) stat_h <= stat_b;
      if (act_s[2] ^ act_s[1]) idle_cnt <= '0;
      else if (!idle)          idle_cnt <= idle_cnt + 1'b1;
      if (reg_wr && sel == REG_CMD && !busy) begin
        cmd_hold <= reg_wdata;
        req_t    <= ~req_t;
      end
      if (reg_wr && sel == REG_IEN) ien <= reg_wdata[0];
      wake <= (wake & ~wake_clr) | (idle & wk_s[1]);
      irq  <= ien & wake;
      if (reg_rd) begin
        case (sel)
          REG_WAKE: reg_rdata <= {{(WORD_W-1){1'b0}}, wake};
          REG_IEN:  reg_rdata <= {{(WORD_W-1){1'b0}}, ien};
          REG_STAT: reg_rdata <= stat_h;
          default:  reg_rdata <= cmd_hold;
        endcase
      end
    end
  end

  assert_drop_busy_write_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == REG_CMD && busy) |=> $stable(cmd_hold));
  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ien && wake));
  assert_wake_needs_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> $past(idle));
endmodule

// File: tb/sim_ac_link_ctrl.sv
module sim_ac_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BCLK_HALF  = 40;
  localparam int FRAME_CLKS = 2048;

  logic clk = 0, rst = 1, bclk = 0, bclk_run = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_word = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, ac_sync, ac_sdout, ac_sdin0, ac_sdin1;
  logic lane0_bit = 0, lane1_bit = 0, wake_force = 0;
  logic [255:0] nxt0 = '0, nxt1 = '0, cur0 = '0, cur1 = '0;
  int vectors = 0, errors = 0;
  logic [31:0] exp_q[$];

  assign ac_sdin0 = lane0_bit;
  assign ac_sdin1 = lane1_bit | wake_force;

  ac_link_ctrl u0 (.clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .bit_clk(bclk), .ac_sync(ac_sync), .ac_sdout(ac_sdout),
    .ac_sdin0(ac_sdin0), .ac_sdin1(ac_sdin1));

  always #(CLK_PERIOD/2) clk = ~clk;
  always begin
    #(BCLK_HALF);
    if (bclk_run) bclk = ~bclk; else bclk = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk); reg_word = w; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk); reg_word = w; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic send_cmd(input logic [31:0] c);
    reg_write(2'd3, c);
    exp_q.push_back(c);
  endtask

  task automatic wait_frames(input int n);
    repeat (n * FRAME_CLKS) @(posedge clk);
  endtask

  function automatic logic [255:0] mk_frame(input bit t14, input bit t13,
                                            input logic [15:0] a, input logic [15:0] d);
    logic [255:0] f = '0;
    f[255] = t14 | t13;
    f[254] = t14;
    f[253] = t13;
    f[239:220] = {a, 4'h0};
    f[219:200] = {d, 4'h0};
    return f;
  endfunction

  // codec model: drives a bit after each rising edge
  int cpos = 256;
  logic cprev = 0;
  always @(posedge bclk) begin
    #1;
    if (ac_sync && !cprev) begin
      cpos = 0; cur0 = nxt0; cur1 = nxt1;
    end
    if (cpos < 256) begin
      lane0_bit = cur0[255 - cpos];
      lane1_bit = cur1[255 - cpos];
      cpos++;
    end
    cprev = ac_sync;
  end

  // monitor / scoreboard on the serial output
  logic [255:0] fb = '0;
  int mpos = 0, sync_len = 0;
  bit mon_on = 0;
  logic sprev = 0;
  always @(negedge bclk) begin
    if (ac_sync && !sprev) begin
      if (mon_on) begin
        check(sync_len == 16 && mpos == 256, "R2 frame/sync length", 32'(sync_len), 32'd16);
        if (fb[254] && fb[253]) begin
          if (exp_q.size() == 0)
            check(0, "R3 unexpected command frame", {fb[239:224], fb[219:204]}, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check({fb[239:224], fb[219:204]} == e && fb[255] && fb[223:220] == 0 &&
                  fb[203:200] == 0 && fb[252:240] == 0 && fb[199:0] == 0,
                  "R3 command frame", {fb[239:224], fb[219:204]}, e);
          end
        end else
          check(fb == '0, "R4 idle frame", fb[255:224], 32'h0);
      end
      mon_on = 1; mpos = 0; sync_len = 0;
    end
    if (mon_on && mpos < 256) begin
      fb[255 - mpos] = ac_sdout;
      if (ac_sync) sync_len++;
      mpos++;
    end
    sprev = ac_sync;
  end

  bit done = 0;
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (50) @(posedge clk);
    @(negedge clk); rst = 0;
    check(ac_sync == 0, "R1 sync low after reset", 32'(ac_sync), 32'h0);
    check(irq == 0, "R1 irq low after reset", 32'(irq), 32'h0);
    for (int w = 0; w < 4; w++) begin
      reg_read(2'(w), d);
      check(d == 0, "R1 register reset value", d, 32'h0);
    end

    // command path
    send_cmd(32'h1234_5678); wait_frames(3);
    send_cmd(32'hFFFF_0000); wait_frames(3);
    send_cmd(32'h8001_0001); wait_frames(3);
    send_cmd(32'hA5A5_3C3C);
    reg_write(2'd3, 32'h0BAD_0BAD);   // R5: busy, must be dropped
    reg_read(2'd3, d);
    check(d == 32'hA5A5_3C3C, "R5 readback of accepted command", d, 32'hA5A5_3C3C);
    wait_frames(3);

    // status path
    nxt0 = mk_frame(1, 1, 16'hA5C3, 16'h0F1E); wait_frames(3);
    reg_read(2'd2, d);
    check(d == 32'hA5C3_0F1E, "R6 status capture", d, 32'hA5C3_0F1E);
    nxt0 = mk_frame(1, 0, 16'h1111, 16'h2222); wait_frames(3);
    reg_read(2'd2, d);
    check(d == 32'hA5C3_0F1E, "R7 slot2 tag clear", d, 32'hA5C3_0F1E);
    nxt0 = mk_frame(0, 1, 16'h3333, 16'h4444); wait_frames(3);
    reg_read(2'd2, d);
    check(d == 32'hA5C3_0F1E, "R7 slot1 tag clear", d, 32'hA5C3_0F1E);
    nxt0 = '0; nxt1 = mk_frame(1, 1, 16'h8421, 16'hF00D); wait_frames(3);
    reg_read(2'd2, d);
    check(d == 32'h8421_F00D, "R8 second input status", d, 32'h8421_F00D);
    nxt0 = mk_frame(1, 1, 16'h7E57, 16'h0001); nxt1 = mk_frame(1, 1, 16'hDEAD, 16'hBEEF);
    wait_frames(3);
    reg_read(2'd2, d);
    check(d == 32'h7E57_0001, "R8 input 0 priority", d, 32'h7E57_0001);
    reg_read(2'd0, d);
    check(d == 0, "R9 no wake while frames run", d, 32'h0);
    nxt0 = '0; nxt1 = '0; wait_frames(2);

    // wake path
    bclk_run = 0;
    repeat (200) @(posedge clk);
    reg_read(2'd0, d);
    check(d == 0, "R9 idle clock, line low", d, 32'h0);
    wake_force = 1;
    repeat (10) @(posedge clk);
    reg_read(2'd0, d);
    check(d == 1, "R9 wake flagged", d, 32'h1);
    check(irq == 0, "R11 irq masked", 32'(irq), 32'h0);
    reg_write(2'd1, 32'h1);
    repeat (4) @(posedge clk);
    check(irq == 1, "R11 irq enabled", 32'(irq), 32'h1);
    reg_read(2'd1, d);
    check(d == 1, "R11 enable readback", d, 32'h1);
    wake_force = 0;
    repeat (4) @(posedge clk);
    reg_write(2'd0, 32'h1);
    repeat (4) @(posedge clk);
    reg_read(2'd0, d);
    check(d == 0, "R10 wake cleared", d, 32'h0);
    check(irq == 0, "R10 irq drops after clear", 32'(irq), 32'h0);
    bclk_run = 1;

    send_cmd(32'hCAFE_BEEF); wait_frames(3);
    check(exp_q.size() == 0, "R3 every command sent once", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule